// File: doc/BRIEF.md
# Erase-Block Write-Back Cache Controller

This controller lets a host treat a serial flash as an array of 512-byte logical sectors, while the flash itself can only be erased in 4 KiB blocks. It keeps one whole erase block in a local buffer. Together with that buffer it holds three flags and the number of the block it currently holds. The valid flag says the buffer holds a block. The dirty flag says the buffer no longer matches flash. The erased flag says the block has been erased in flash since it was loaded.

A sector write or sector erase that lands in the buffer only changes the buffer. The first such change to a freshly loaded block erases that block in flash. The whole block is programmed back later, either when a different block is needed or when the host asks for a flush. Each small write therefore becomes a read-erase-modify-program cycle on the whole block, and a run of sectors within one block costs one erase and one program.

The controller issues its flash work as whole-block operations on a request/acknowledge port: block read, block erase and block program. It has at most one such operation open at a time. The signalling on the flash wires is handled by another block behind that port. Sector data moves one 64-bit word per cycle on both sides.

Top module: `sector_cache`

## Requirements
- R1: After reset the buffer is invalid, clean and not erased: `host_ready` is 1, `fl_req`, `rd_valid` and `host_wready` are 0, and the first sector access of any kind is a miss that issues a block read.
- R2: Logical sector number `s` maps to erase block `s >> 3` and to slot `s & 7` within the buffer. Word `w` of the sector lives at buffer word `(s & 7)*64 + w`, which is flash word `(s >> 3)*512 + (s & 7)*64 + w`.
- R3: A request (host op code 0 read, 1 write, 2 erase) whose block is not the cached one, or that arrives while the buffer is invalid, first writes the buffer back if it is dirty or erased. It then issues a block read (flash op code 0) for the new block. A later request to the same block issues no flash operation on its own account.
- R4: A flush (host op code 3) issues a block program (flash op code 2) of all 512 buffer words only when the dirty or erased flag is set, and then clears both flags. A flush of a clean, unerased buffer issues nothing. After a program, the flash block equals the logical contents.
- R5: A write or erase request that finds the erased flag clear first issues a block erase (flash op code 1) for the cached block and sets the erased flag. Further writes or erases to the same block issue no erase.
- R6: An erase request sets all 64 words of the slot to all ones and sets dirty, with no program issued. A later read of that sector returns all ones.
- R7: A write request takes exactly 64 words on `host_wvalid`/`host_wready` into the slot and sets dirty, with no program issued until a flush or an eviction.
- R8: At most one flash operation is open. `fl_req` stays high, with `fl_op` and `fl_block` unchanged, until `fl_ack`, and `host_ready` is low while `fl_req` is high.
- R9: A read request returns the 64 words of the sector on `rd_valid`/`rd_data` in 64 consecutive cycles, in ascending word order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_valid | input | 1 | Host request present |
| host_ready | output | 1 | Controller idle and taking a request |
| host_op | input | 2 | 0 read, 1 write, 2 erase, 3 flush |
| host_sector | input | LSN_W (16) | Logical 512-byte sector number |
| host_wvalid | input | 1 | Write data word present |
| host_wready | output | 1 | Controller taking write data words |
| host_wdata | input | DW (64) | Write data word |
| rd_valid | output | 1 | Read data word present |
| rd_data | output | DW (64) | Read data word |
| fl_req | output | 1 | Flash operation requested, held until acknowledge |
| fl_ack | input | 1 | Flash operation finished |
| fl_op | output | 2 | 0 block read, 1 block erase, 2 block program |
| fl_block | output | LSN_W-3 (13) | Erase block number of the operation |
| fl_wvalid | output | 1 | Program data word present |
| fl_wdata | output | DW (64) | Program data word, ascending order |
| fl_rvalid | input | 1 | Block read data word present |
| fl_rdata | input | DW (64) | Block read data word, ascending order |

## Verification
A directed sequence steps the flag combinations in turn. It covers a cold miss, hits on sectors in the loaded block, the first write (with erase) against a second write (without), and a sector erase followed by a read-back of ones. It also covers a flush of a dirty buffer against a flush of a clean one, and evictions of clean and of dirty blocks. Each of these tells apart a refill, erase or program that is issued from one that is skipped. Random reads, writes, erases and flushes then run over four neighbouring blocks, so hits and evictions mix. The flash model ANDs each program into its contents, so an erase that was missed, or a write-back of stale data, shows up as wrong data in flash or on read-back.

// File: rtl/sector_cache_pkg.sv
package sector_cache_pkg;

    typedef enum logic [1:0] {
        HOP_READ  = 2'd0,
        HOP_WRITE = 2'd1,
        HOP_ERASE = 2'd2,
        HOP_FLUSH = 2'd3
    } hop_e;

    typedef enum logic [1:0] {
        FOP_READ  = 2'd0,
        FOP_ERASE = 2'd1,
        FOP_PROG  = 2'd2
    } fop_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_WB    = 3'd1,
        ST_FILL  = 3'd2,
        ST_ERASE = 3'd3,
        ST_WDATA = 3'd4,
        ST_ONES  = 3'd5,
        ST_RD    = 3'd6
    } sc_state_e;

endpackage

// File: rtl/sc_index.sv
module sc_index #(
    parameter int LSN_W  = 16,
    parameter int SLOT_W = 3
) (
    input  logic [LSN_W-1:0]        lsn,
    output logic [LSN_W-SLOT_W-1:0] blk,
    output logic [SLOT_W-1:0]       slot
);
    // upper bits pick the erase block, lower bits the 512-byte slot in it
    assign blk  = lsn[LSN_W-1:SLOT_W];
    assign slot = lsn[SLOT_W-1:0];
endmodule

// File: rtl/sc_buffer.sv
module sc_buffer #(
    parameter int DW = 64,
    parameter int AW = 9
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/sector_cache.sv
module sector_cache #(
    parameter int DW        = 64,
    parameter int LSN_W     = 16,
    parameter int BLK_SHIFT = 12
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           host_valid,
    output logic                           host_ready,
    input  logic [1:0]                     host_op,
    input  logic [LSN_W-1:0]               host_sector,
    input  logic                           host_wvalid,
    output logic                           host_wready,
    input  logic [DW-1:0]                  host_wdata,
    output logic                           rd_valid,
    output logic [DW-1:0]                  rd_data,
    output logic                           fl_req,
    input  logic                           fl_ack,
    output logic [1:0]                     fl_op,
    output logic [LSN_W-(BLK_SHIFT-9)-1:0] fl_block,
    output logic                           fl_wvalid,
    output logic [DW-1:0]                  fl_wdata,
    input  logic                           fl_rvalid,
    input  logic [DW-1:0]                  fl_rdata
);
    import sector_cache_pkg::*;

    localparam int SLOT_W = BLK_SHIFT - 9;
    localparam int BLK_W  = LSN_W - SLOT_W;
    localparam int WPS    = (512 * 8) / DW;
    localparam int WS_W   = $clog2(WPS);
    localparam int WA_W   = WS_W + SLOT_W;
    localparam int WPB    = 1 << WA_W;

    typedef struct packed {
        sc_state_e         st;
        logic              vld;
        logic              dty;
        logic              ers;
        logic [BLK_W-1:0]  blk;
        hop_e              op;
        logic [SLOT_W-1:0] slot;
        logic [BLK_W-1:0]  tgt;
        logic [WA_W:0]     cnt;
        logic              freq;
        fop_e              fop;
        logic [BLK_W-1:0]  fblk;
        logic              fwv;
        logic [DW-1:0]     fwd;
        logic              rdv;
        logic [DW-1:0]     rdd;
    } ctl_t;

    ctl_t q, n;

    logic [BLK_W-1:0]  ix_blk;
    logic [SLOT_W-1:0] ix_slot;
    logic              mem_we;
    logic [WA_W-1:0]   mem_waddr;
    logic [DW-1:0]     mem_wdata;
    logic [WA_W-1:0]   mem_raddr;
    logic [DW-1:0]     mem_rdata;
    logic              disp;
    logic              sec_last;

    sc_index #(.LSN_W(LSN_W), .SLOT_W(SLOT_W)) u_index (
        .lsn  (host_sector),
        .blk  (ix_blk),
        .slot (ix_slot)
    );

    sc_buffer #(.DW(DW), .AW(WA_W)) u_buffer (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .raddr (mem_raddr),
        .rdata (mem_rdata)
    );

    assign sec_last = (q.cnt[WS_W-1:0] == {WS_W{1'b1}});

    always_comb begin
        n         = q;
        n.fwv     = 1'b0;
        n.rdv     = 1'b0;
        mem_we    = 1'b0;
        mem_waddr = q.cnt[WA_W-1:0];
        mem_wdata = '0;
        mem_raddr = q.cnt[WA_W-1:0];
        disp      = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (host_valid) begin
                    n.op   = hop_e'(host_op);
                    n.slot = ix_slot;
                    n.tgt  = ix_blk;
                    n.cnt  = '0;
                    if (hop_e'(host_op) == HOP_FLUSH) begin
                        if (q.dty || q.ers) begin
                            n.st = ST_WB; n.freq = 1'b1; n.fop = FOP_PROG; n.fblk = q.blk;
                        end
                    end else if (!q.vld || (q.blk != ix_blk)) begin
                        if (q.dty || q.ers) begin
                            n.st = ST_WB; n.freq = 1'b1; n.fop = FOP_PROG; n.fblk = q.blk;
                        end else begin
                            n.st = ST_FILL; n.freq = 1'b1; n.fop = FOP_READ; n.fblk = ix_blk;
                        end
                    end else begin
                        disp = 1'b1;
                    end
                end
            end
            ST_WB: begin
                // stream the whole buffer, then wait for the program to finish
                if (q.cnt < (WA_W+1)'(WPB)) begin
                    n.fwv = 1'b1;
                    n.fwd = mem_rdata;
                    n.cnt = q.cnt + 1'b1;
                end
                if (fl_ack) begin
                    n.freq = 1'b0;
                    n.dty  = 1'b0;
                    n.ers  = 1'b0;
                    n.cnt  = '0;
                    if (q.op == HOP_FLUSH) begin
                        n.st = ST_IDLE;
                    end else begin
                        n.st = ST_FILL; n.freq = 1'b1; n.fop = FOP_READ; n.fblk = q.tgt;
                    end
                end
            end
            ST_FILL: begin
                if (fl_rvalid) begin
                    mem_we    = 1'b1;
                    mem_wdata = fl_rdata;
                    n.cnt     = q.cnt + 1'b1;
                end
                if (fl_ack) begin
                    n.freq = 1'b0;
                    n.vld  = 1'b1;
                    n.dty  = 1'b0;
                    n.ers  = 1'b0;
                    n.blk  = q.tgt;
                    disp   = 1'b1;
                end
            end
            ST_ERASE: begin
                if (fl_ack) begin
                    n.freq = 1'b0;
                    n.ers  = 1'b1;
                    n.cnt  = '0;
                    n.st   = (q.op == HOP_WRITE) ? ST_WDATA : ST_ONES;
                end
            end
            ST_WDATA: begin
                mem_waddr = {q.slot, q.cnt[WS_W-1:0]};
                mem_wdata = host_wdata;
                if (host_wvalid) begin
                    mem_we = 1'b1;
                    n.cnt  = q.cnt + 1'b1;
                    if (sec_last) begin
                        n.dty = 1'b1;
                        n.st  = ST_IDLE;
                    end
                end
            end
            ST_ONES: begin
                mem_waddr = {q.slot, q.cnt[WS_W-1:0]};
                mem_wdata = '1;
                mem_we    = 1'b1;
                n.cnt     = q.cnt + 1'b1;
                if (sec_last) begin
                    n.dty = 1'b1;
                    n.st  = ST_IDLE;
                end
            end
            ST_RD: begin
                mem_raddr = {q.slot, q.cnt[WS_W-1:0]};
                n.rdv     = 1'b1;
                n.rdd     = mem_rdata;
                n.cnt     = q.cnt + 1'b1;
                if (sec_last) n.st = ST_IDLE;
            end
            default: n.st = ST_IDLE;
        endcase

        // the block is resident: decide the sector-level step
        if (disp) begin
            n.cnt = '0;
            if (n.op == HOP_READ) begin
                n.st = ST_RD;
            end else if (!n.ers) begin
                n.st = ST_ERASE; n.freq = 1'b1; n.fop = FOP_ERASE; n.fblk = n.blk;
            end else begin
                n.st = (n.op == HOP_WRITE) ? ST_WDATA : ST_ONES;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign host_ready  = (q.st == ST_IDLE);
    assign host_wready = (q.st == ST_WDATA);
    assign rd_valid    = q.rdv;
    assign rd_data     = q.rdd;
    assign fl_req      = q.freq;
    assign fl_op       = q.fop;
    assign fl_block    = q.fblk;
    assign fl_wvalid   = q.fwv;
    assign fl_wdata    = q.fwd;
endmodule

// File: rtl/sector_cache_chk.sv
module sector_cache_chk #(
    parameter int BW = 13
) (
    input logic          clk,
    input logic          rst_n,
    input logic          host_ready,
    input logic          host_wready,
    input logic          rd_valid,
    input logic          fl_req,
    input logic          fl_ack,
    input logic [1:0]    fl_op,
    input logic [BW-1:0] fl_block
);
    // R8: an open flash operation keeps its request, code and block
    assert_req_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_req && !fl_ack) |=> (fl_req && $stable(fl_op) && $stable(fl_block)));

    // R8: the request only drops after an acknowledge
    assert_req_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fl_req) |-> $past(fl_ack));

    // R8: no host request is taken while a flash operation is open
    assert_host_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        host_ready |-> !fl_req);

    // R7: write data is taken only with no flash operation open
    assert_wdata_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        host_wready |-> !fl_req);

    // R9: read data is never returned while flash is being worked
    assert_rd_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> !fl_req);
endmodule

bind sector_cache sector_cache_chk #(.BW(BLK_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_ready  (host_ready),
    .host_wready (host_wready),
    .rd_valid    (rd_valid),
    .fl_req      (fl_req),
    .fl_ack      (fl_ack),
    .fl_op       (fl_op),
    .fl_block    (fl_block)
);

// File: tb/sector_cache_tb.sv
module sector_cache_tb;
    localparam int DW    = 64;
    localparam int LSN_W = 16;
    localparam int BLK_W = LSN_W - 3;
    localparam int NW    = 4096; // eight blocks of 512 words in the model

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             host_valid = 1'b0;
    logic             host_ready;
    logic [1:0]       host_op = 2'd0;
    logic [LSN_W-1:0] host_sector = '0;
    logic             host_wvalid = 1'b0;
    logic             host_wready;
    logic [DW-1:0]    host_wdata = '0;
    logic             rd_valid;
    logic [DW-1:0]    rd_data;
    logic             fl_req;
    logic             fl_ack = 1'b0;
    logic [1:0]       fl_op;
    logic [BLK_W-1:0] fl_block;
    logic             fl_wvalid;
    logic [DW-1:0]    fl_wdata;
    logic             fl_rvalid = 1'b0;
    logic [DW-1:0]    fl_rdata = '0;

    always #4 clk = ~clk; // 125 MHz

    sector_cache u_dut (
        .clk(clk), .rst_n(rst_n),
        .host_valid(host_valid), .host_ready(host_ready), .host_op(host_op),
        .host_sector(host_sector), .host_wvalid(host_wvalid), .host_wready(host_wready),
        .host_wdata(host_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
        .fl_req(fl_req), .fl_ack(fl_ack), .fl_op(fl_op), .fl_block(fl_block),
        .fl_wvalid(fl_wvalid), .fl_wdata(fl_wdata), .fl_rvalid(fl_rvalid), .fl_rdata(fl_rdata)
    );

    int checks = 0;
    int errors = 0;
    int n_rd = 0, n_er = 0, n_pg = 0;
    int last_rd_blk = -1, last_er_blk = -1, last_pg_blk = -1;
    int r8_bad = 0;
    int range_bad = 0;

    logic [DW-1:0] flash_m [NW];
    logic [DW-1:0] ref_m   [NW];
    logic [DW-1:0] pbuf    [512];
    logic [DW-1:0] wdat    [64];
    logic [DW-1:0] rbuf    [64];

    // bench view of the flags, from the requirements
    bit b_vld = 0, b_dty = 0, b_ers = 0;
    int b_blk = 0;

    function automatic logic [DW-1:0] init_word(int a);
        return {32'h5EC0_0000 | a[31:0], 32'h1234_5678 ^ (a[31:0] * 32'h9E37)};
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint unsigned act, input longint unsigned exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // R8 monitor: host side stalled while a flash operation is open
    always @(negedge clk) begin
        if (rst_n && fl_req && host_ready) r8_bad++;
    end

    // flash model: one operation at a time, programs AND into the array
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && fl_req) begin
                automatic int op  = int'(fl_op);
                automatic int blk = int'(fl_block);
                if (blk > 7) range_bad++;
                blk = blk & 7;
                if (op == 0) begin
                    n_rd++; last_rd_blk = blk;
                    for (int i = 0; i < 512; i++) begin
                        fl_rvalid = 1'b1;
                        fl_rdata  = flash_m[blk*512 + i];
                        @(negedge clk);
                    end
                    fl_rvalid = 1'b0;
                    fl_ack = 1'b1;
                    @(negedge clk);
                    fl_ack = 1'b0;
                end else if (op == 1) begin
                    n_er++; last_er_blk = blk;
                    repeat (3) @(negedge clk);
                    for (int i = 0; i < 512; i++) flash_m[blk*512 + i] = '1;
                    fl_ack = 1'b1;
                    @(negedge clk);
                    fl_ack = 1'b0;
                end else begin
                    automatic int got = 0;
                    n_pg++; last_pg_blk = blk;
                    while (got < 512) begin
                        if (fl_wvalid) begin
                            pbuf[got] = fl_wdata;
                            got++;
                        end
                        if (got < 512) @(negedge clk);
                    end
                    for (int i = 0; i < 512; i++)
                        flash_m[blk*512 + i] = flash_m[blk*512 + i] & pbuf[i];
                    @(negedge clk);
                    fl_ack = 1'b1;
                    @(negedge clk);
                    fl_ack = 1'b0;
                end
            end
        end
    end

    task automatic cmp_block(input int blk, input string tag);
        automatic int bad = -1;
        for (int i = 0; i < 512; i++)
            if (bad < 0 && flash_m[blk*512 + i] !== ref_m[blk*512 + i]) bad = i;
        if (bad < 0) chk(1'b1, tag, "flash block contents", 0, 0);
        else chk(1'b0, tag, $sformatf("flash block %0d word %0d", blk, bad),
                 flash_m[blk*512 + bad], ref_m[blk*512 + bad]);
    endtask

    // op: 0 read, 1 write, 2 erase, 3 flush
    task automatic do_op(input int op, input int lsn, input string tag);
        automatic int blk = lsn >> 3;
        automatic int e_rd = 0, e_er = 0, e_pg = 0;
        automatic int pg_blk = -1, er_blk = -1;
        automatic int s_rd = n_rd, s_er = n_er, s_pg = n_pg;
        automatic int wi = 0, got = 0;
        // expected flash work
        if (op != 3) begin
            if (!b_vld || b_blk != blk) begin
                if (b_dty || b_ers) begin e_pg = 1; pg_blk = b_blk; end
                e_rd = 1;
                b_vld = 1; b_blk = blk; b_dty = 0; b_ers = 0;
            end
            if (op == 1 || op == 2) begin
                if (!b_ers) begin e_er = 1; er_blk = blk; b_ers = 1; end
                b_dty = 1;
            end
        end else if (b_dty || b_ers) begin
            e_pg = 1; pg_blk = b_blk; b_dty = 0; b_ers = 0;
        end
        if (op == 1) for (int i = 0; i < 64; i++) wdat[i] = {$urandom, $urandom};

        @(negedge clk);
        while (!host_ready) @(negedge clk);
        host_valid  = 1'b1;
        host_op     = op[1:0];
        host_sector = lsn[LSN_W-1:0];
        @(negedge clk);
        host_valid = 1'b0;
        forever begin
            host_wvalid = 1'b0;
            if (op == 1 && host_wready && wi < 64) begin
                host_wvalid = 1'b1;
                host_wdata  = wdat[wi];
                wi++;
            end
            if (rd_valid) begin
                if (got < 64) rbuf[got] = rd_data;
                got++;
            end
            if (host_ready && !(op == 0 && got < 64) && !host_wvalid) break;
            @(negedge clk);
        end
        host_wvalid = 1'b0;
        @(negedge clk);

        chk(((n_rd - s_rd) == e_rd) && ((n_er - s_er) == e_er) && ((n_pg - s_pg) == e_pg),
            tag, $sformatf("flash ops {read,erase,program} op=%0d sector=%0d", op, lsn),
            ((n_rd - s_rd) << 8) | ((n_er - s_er) << 4) | (n_pg - s_pg),
            (e_rd << 8) | (e_er << 4) | e_pg);
        if (e_rd) chk(last_rd_blk == blk, "R3", "refill block", last_rd_blk, blk);
        if (e_er) chk(last_er_blk == er_blk, "R5", "erase block", last_er_blk, er_blk);
        if (e_pg) begin
            chk(last_pg_blk == pg_blk, "R4", "program block", last_pg_blk, pg_blk);
            cmp_block(pg_blk, "R4");
        end
        if (op == 1) chk(wi == 64, "R7", "write words taken", wi, 64);
        if (op == 0) begin
            automatic int bad = -1;
            chk(got == 64, "R9", "read words returned", got, 64);
            for (int i = 0; i < 64; i++)
                if (bad < 0 && rbuf[i] !== ref_m[lsn*64 + i]) bad = i;
            if (bad < 0) chk(1'b1, tag, "read data", 0, 0);
            else chk(1'b0, tag, $sformatf("read sector %0d word %0d", lsn, bad),
                     rbuf[bad], ref_m[lsn*64 + bad]);
        end
        // logical contents after the operation
        if (op == 1) for (int i = 0; i < 64; i++) ref_m[lsn*64 + i] = wdat[i];
        if (op == 2) for (int i = 0; i < 64; i++) ref_m[lsn*64 + i] = '1;
    endtask

    bit done = 0;

    initial begin
        void'($urandom(32'd20251));
        for (int a = 0; a < NW; a++) begin
            flash_m[a] = init_word(a);
            ref_m[a]   = init_word(a);
        end
        repeat (4) @(negedge clk);
        // R1: reset state at the ports
        chk(host_ready == 1'b1, "R1", "host_ready after reset", host_ready, 1);
        chk(fl_req == 1'b0 && rd_valid == 1'b0 && host_wready == 1'b0, "R1",
            "req/rd_valid/wready after reset", {fl_req, rd_valid, host_wready}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        do_op(0, 5, "R1");   // cold miss: block read of block 0
        do_op(0, 2, "R3");   // hit, no flash work
        do_op(1, 3, "R5");   // first write: erase then fill
        do_op(1, 4, "R7");   // second write: no erase, no program
        do_op(2, 6, "R6");   // sector erase: buffer only
        do_op(0, 6, "R6");   // reads back all ones
        do_op(0, 3, "R2");   // written sector, slot 3
        do_op(3, 0, "R4");   // dirty flush programs
        do_op(3, 0, "R4");   // clean flush issues nothing
        do_op(0, 9, "R3");   // clean eviction: read only
        do_op(1, 9, "R5");   // erase of block 1 then write
        do_op(0, 20, "R3");  // dirty eviction: program block 1, read block 2
        do_op(0, 9, "R2");   // block 1 again, from flash
        do_op(2, 23, "R6");  // erase in block 2

        for (int k = 0; k < 40; k++) begin
            automatic int r = $urandom % 10;
            automatic int s = $urandom % 32;
            automatic int o = (r < 4) ? 0 : (r < 7) ? 1 : (r < 9) ? 2 : 3;
            do_op(o, s, o == 0 ? "R9" : o == 1 ? "R7" : o == 2 ? "R6" : "R4");
        end

        do_op(3, 0, "R4");
        for (int b = 0; b < 8; b++) cmp_block(b, "R4");
        chk(r8_bad == 0, "R8", "host_ready high while flash request open", r8_bad, 0);
        chk(range_bad == 0, "R2", "flash block out of range", range_bad, 0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule